// File: doc/BRIEF.md
# Suspend and Wake Sequencer

This block steers a chip region into and out of a low-power suspend state. An external suspend request is brought into the clock domain through a two-flop synchronizer. A glitch filter can be switched on to qualify it. A rising qualified request starts an entry sequence and a falling one starts a wake sequence. The block drives an `awake` status output and three global controls:

- `wp_lock`: a write lock on all clocked storage.
- `out_hold`: a hold that parks the outputs in their suspend behaviour.
- `in_disable`: a disable for the inputs and interconnect.

A single counter spaces these controls in a fixed order in each direction. The spacing intervals are fixed by parameters. After `awake` rises, the write lock and the output hold are released after two separate programmable delays, each from 1 to 512 cycles. The wake timing depends only on this internal sequencing. It never waits for any clock-manager lock indication.

Top module: `susp_seq`

## Requirements
- R1: After reset, `awake` is 1 and `wp_lock`, `out_hold` and `in_disable` are all 0.
- R2: With `filter_en`=0, `wp_lock` rises on the 4th rising clock edge after `suspend_req` rises. The delay comes from two synchronizer flops, one qualified-level register and the state register.
- R3: On entry, `awake` falls WP_TO_AWAKE cycles after `wp_lock` rises. `out_hold` rises AWAKE_TO_OUT cycles after that. `in_disable` rises OUT_TO_IN cycles after that. `awake` is never 0 while `wp_lock` is 0.
- R4: With `filter_en`=1, the synchronized level must differ from the qualified level for FILTER_CYCLES consecutive cycles before it is accepted. Each entry and exit event therefore moves FILTER_CYCLES-1 cycles later than with the filter off.
- R5: With `filter_en`=1, a request pulse shorter than FILTER_CYCLES cycles has no effect on any output.
- R6: On exit, `in_disable` falls on the 4th rising edge after `suspend_req` falls (filter off). `awake` rises IN_TO_AWAKE cycles later.
- R7: `wp_lock` falls N cycles after `awake` rises, where N is the effective value of `wp_cycles`.
- R8: `out_hold` falls M cycles after `awake` rises, where M is the effective value of `hold_cycles`. M is independent of `wp_cycles`.
- R9: A delay input of 0 acts as 1, and a delay input above 512 acts as 512.
- R10: If the qualified request rises again during the wake sequence (after `in_disable` fell), the block goes straight to full suspend. On the 4th edge after the request rises, `awake` is 0 and `wp_lock`, `out_hold` and `in_disable` are all 1.
- R11: Once entry has begun, it runs to full suspend even if the request falls meanwhile. The wake sequence then starts on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| suspend_req | input | 1 | Asynchronous suspend request, active high |
| filter_en | input | 1 | 1 enables the glitch filter on the request |
| wp_cycles | input | CYC_W | Cycles from `awake` rising to write-lock release |
| hold_cycles | input | CYC_W | Cycles from `awake` rising to output-hold release |
| awake | output | 1 | High when the block is awake |
| wp_lock | output | 1 | Global write lock for clocked storage |
| out_hold | output | 1 | Global hold of outputs in suspend behaviour |
| in_disable | output | 1 | Disable for inputs and interconnect |

## Verification
The hardest state to reach is an aborted wake. The request has to rise again inside the short window after `awake` rises and before the longer of the two release delays expires. The write lock must already be released at that point, so the re-lock is visible. The bench first runs a complete entry. It then sets a short write-lock delay and a long hold delay, drops the request, and waits for `awake` to rise. It counts ten edges and then raises the request. Every transition is timed by counting edges from the cycle the input changed, so any shift in the pipeline depth shows up as a cycle count mismatch.

// File: rtl/susp_seq.sv
module susp_seq #(
  parameter int FILTER_CYCLES = 8,
  parameter int WP_TO_AWAKE   = 2,
  parameter int AWAKE_TO_OUT  = 3,
  parameter int OUT_TO_IN     = 20,
  parameter int IN_TO_AWAKE   = 2,
  parameter int MAX_REL       = 512,
  parameter int CYC_W         = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspend_req,
  input  logic             filter_en,
  input  logic [CYC_W-1:0] wp_cycles,
  input  logic [CYC_W-1:0] hold_cycles,
  output logic             awake,
  output logic             wp_lock,
  output logic             out_hold,
  output logic             in_disable
);

  localparam int FW    = $clog2(FILTER_CYCLES + 1);
  localparam int SP_A  = (WP_TO_AWAKE > AWAKE_TO_OUT) ? WP_TO_AWAKE : AWAKE_TO_OUT;
  localparam int SP_B  = (OUT_TO_IN > IN_TO_AWAKE) ? OUT_TO_IN : IN_TO_AWAKE;
  localparam int SPMAX = (SP_A > SP_B) ? SP_A : SP_B;
  localparam int CW    = $clog2(((SPMAX > MAX_REL) ? SPMAX : MAX_REL) + 1);

  typedef enum logic [2:0] {
    ST_AWAKE, ST_ENTER_WP, ST_ENTER_OUT, ST_ENTER_IN,
    ST_SUSPENDED, ST_EXIT_IN, ST_EXIT_AWAKE, ST_RELEASE
  } state_t;

  function automatic logic [CW-1:0] eff_delay(input logic [CYC_W-1:0] v);
    int x;
    x = int'(v);
    if (x == 0) x = 1;
    else if (x > MAX_REL) x = MAX_REL;
    return CW'(x);
  endfunction

  logic          s_meta, s_sync, req_q;
  logic [FW-1:0] flt_cnt;
  state_t        st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] wp_n, hold_n, rel_max;

  assign wp_n    = eff_delay(wp_cycles);
  assign hold_n  = eff_delay(hold_cycles);
  assign rel_max = (wp_n > hold_n) ? wp_n : hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
    end else begin
      s_meta <= suspend_req;
      s_sync <= s_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      flt_cnt <= '0;
    end else if (!filter_en) begin
      req_q   <= s_sync;
      flt_cnt <= '0;
    end else if (s_sync == req_q) begin
      flt_cnt <= '0;
    end else if (flt_cnt == FW'(FILTER_CYCLES - 1)) begin
      req_q   <= s_sync;
      flt_cnt <= '0;
    end else begin
      flt_cnt <= flt_cnt + 1'b1;
    end
  end

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_AWAKE:
        if (req_q) begin
          st_n  = ST_ENTER_WP;
          cnt_n = CW'(WP_TO_AWAKE - 1);
        end
      ST_ENTER_WP:
        if (cnt == '0) begin
          st_n  = ST_ENTER_OUT;
          cnt_n = CW'(AWAKE_TO_OUT - 1);
        end else cnt_n = cnt - 1'b1;
      ST_ENTER_OUT:
        if (cnt == '0) begin
          st_n  = ST_ENTER_IN;
          cnt_n = CW'(OUT_TO_IN - 1);
        end else cnt_n = cnt - 1'b1;
      ST_ENTER_IN:
        if (cnt == '0) st_n = ST_SUSPENDED;
        else cnt_n = cnt - 1'b1;
      ST_SUSPENDED:
        if (!req_q) begin
          st_n  = ST_EXIT_IN;
          cnt_n = CW'(IN_TO_AWAKE - 1);
        end
      ST_EXIT_IN:
        if (req_q) st_n = ST_SUSPENDED;
        else if (cnt == '0) st_n = ST_EXIT_AWAKE;
        else cnt_n = cnt - 1'b1;
      ST_EXIT_AWAKE:
        if (req_q) st_n = ST_SUSPENDED;
        else begin
          st_n  = ST_RELEASE;
          cnt_n = CW'(1);
        end
      ST_RELEASE:
        if (req_q) st_n = ST_SUSPENDED;
        else if (cnt >= rel_max) st_n = ST_AWAKE;
        else cnt_n = cnt + 1'b1;
      default: st_n = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_AWAKE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign awake      = (st == ST_AWAKE) || (st == ST_ENTER_WP) ||
                      (st == ST_EXIT_AWAKE) || (st == ST_RELEASE);
  assign wp_lock    = (st == ST_RELEASE) ? (cnt < wp_n) : (st != ST_AWAKE);
  assign out_hold   = (st == ST_RELEASE) ? (cnt < hold_n) :
                      ((st == ST_ENTER_IN) || (st == ST_SUSPENDED) ||
                       (st == ST_EXIT_IN) || (st == ST_EXIT_AWAKE));
  assign in_disable = (st == ST_SUSPENDED);

endmodule

// File: rtl/susp_seq_sva.sv
module susp_seq_sva (
  input logic clk,
  input logic rst_n,
  input logic awake,
  input logic wp_lock,
  input logic out_hold,
  input logic in_disable
);

  AST_LOCK_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> wp_lock);  // R3

  AST_LOCK_BEFORE_AWAKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(awake) && !in_disable) |-> $past(wp_lock));  // R3

  AST_HOLD_AFTER_AWAKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_hold) |-> !awake);  // R3

  AST_ENABLE_BEFORE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> (!in_disable && $past(!in_disable)));  // R6

  AST_LOCK_RELEASE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_lock) |-> awake);  // R7

  AST_HOLD_RELEASE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_hold) |-> awake);  // R8

  AST_FULL_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    in_disable |-> (!awake && wp_lock && out_hold));  // R10

endmodule

bind susp_seq susp_seq_sva u_susp_seq_sva (
  .clk(clk), .rst_n(rst_n), .awake(awake), .wp_lock(wp_lock),
  .out_hold(out_hold), .in_disable(in_disable)
);

// File: tb/susp_seq_bench.sv
`timescale 1ns/1ps
module susp_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       suspend_req = 1'b0;
  logic       filter_en = 1'b0;
  logic [9:0] wp_cycles = 10'd1;
  logic [9:0] hold_cycles = 10'd1;
  logic       awake, wp_lock, out_hold, in_disable;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  susp_seq u_susp_seq (
    .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req), .filter_en(filter_en),
    .wp_cycles(wp_cycles), .hold_cycles(hold_cycles), .awake(awake),
    .wp_lock(wp_lock), .out_hold(out_hold), .in_disable(in_disable)
  );

  function automatic logic sig(input int sel);
    case (sel)
      0: return awake;
      1: return wp_lock;
      2: return out_hold;
      default: return in_disable;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int sel, input logic val, inout int t);
    int n = 0;
    while (sig(sel) !== val && n < 2000) begin
      @(posedge clk); #2;
      t++; n++;
    end
  endtask

  task automatic drive_req(input logic v);
    @(negedge clk);
    suspend_req = v;
  endtask

  task automatic t_reset;
    chk("R1 awake", awake, 1);
    chk("R1 wp_lock", wp_lock, 0);
    chk("R1 out_hold", out_hold, 0);
    chk("R1 in_disable", in_disable, 0);
  endtask

  task automatic t_entry_nofilter;
    int t = 0;
    drive_req(1'b1);
    step(1, 1'b1, t); chk("R2 wp_lock rise edge", t, 4);
    step(0, 1'b0, t); chk("R3 awake fall edge", t, 6);
    step(2, 1'b1, t); chk("R3 out_hold rise edge", t, 9);
    step(3, 1'b1, t); chk("R3 in_disable rise edge", t, 29);
  endtask

  task automatic t_exit_basic;
    int t = 0;
    wp_cycles = 10'd5; hold_cycles = 10'd9;
    drive_req(1'b0);
    step(3, 1'b0, t); chk("R6 in_disable fall edge", t, 4);
    step(0, 1'b1, t); chk("R6 awake rise edge", t, 6);
    step(1, 1'b0, t); chk("R7 wp_lock release edge", t, 11);
    step(2, 1'b0, t); chk("R8 out_hold release edge", t, 15);
  endtask

  task automatic t_glitch;
    int bad = 0;
    filter_en = 1'b1;
    repeat (3) @(negedge clk);
    drive_req(1'b1);
    repeat (4) @(negedge clk);
    suspend_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      if (!awake || wp_lock || out_hold || in_disable) bad++;
    end
    chk("R5 glitch disturbed outputs cycles", bad, 0);
  endtask

  task automatic t_filter_and_clamp;
    int t = 0;
    drive_req(1'b1);
    step(1, 1'b1, t); chk("R4 filtered wp_lock rise edge", t, 11);
    step(3, 1'b1, t); chk("R4 filtered in_disable rise edge", t, 36);
    wp_cycles = 10'd0; hold_cycles = 10'd1023;
    t = 0;
    drive_req(1'b0);
    step(3, 1'b0, t); chk("R4 filtered in_disable fall edge", t, 11);
    step(0, 1'b1, t); chk("R4 filtered awake rise edge", t, 13);
    step(1, 1'b0, t); chk("R9 zero delay acts as one", t, 14);
    step(2, 1'b0, t); chk("R9 large delay clamps to 512", t, 525);
    filter_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_abort;
    int t = 0;
    drive_req(1'b1);
    step(3, 1'b1, t);
    wp_cycles = 10'd3; hold_cycles = 10'd50;
    t = 0;
    drive_req(1'b0);
    step(0, 1'b1, t);
    repeat (10) @(posedge clk);
    #2;
    chk("R10 lock released before abort", wp_lock, 0);
    t = 0;
    drive_req(1'b1);
    step(0, 1'b0, t); chk("R10 abort awake fall edge", t, 4);
    chk("R10 abort wp_lock", wp_lock, 1);
    chk("R10 abort out_hold", out_hold, 1);
    chk("R10 abort in_disable", in_disable, 1);
    t = 0;
    drive_req(1'b0);
    step(2, 1'b0, t); chk("R8 hold release after abort exit", t, 56);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_entry_committed;
    int t = 0;
    wp_cycles = 10'd2; hold_cycles = 10'd2;
    drive_req(1'b1);
    step(2, 1'b1, t); chk("R11 out_hold rise edge", t, 9);
    @(negedge clk); suspend_req = 1'b0;
    step(3, 1'b1, t); chk("R11 in_disable still rises edge", t, 29);
    step(3, 1'b0, t); chk("R11 wake starts next edge", t, 30);
    step(0, 1'b1, t); chk("R11 awake rise edge", t, 32);
    step(1, 1'b0, t); chk("R11 wp_lock release edge", t, 34);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_entry_nofilter();
    t_exit_basic();
    t_glitch();
    t_filter_and_clamp();
    t_abort();
    t_entry_committed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule